// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary floating-point words (1 sign bit, 8-bit biased exponent, 23-bit fraction) and forms their product. The significands, with the hidden one restored, are multiplied into a 48-bit product. A single test of the product's top bit normalizes it. The fraction is cut to 23 bits without rounding. The exponents are summed and rebiased in a 10-bit signed intermediate, so that values beyond either end of the 8-bit field are caught before they wrap.

Both operands and the result are sorted into five classes: zero, denormal, normal, infinity and NaN. Exceptional operands override the arithmetic path:
- An invalid combination returns the quiet NaN 0x7FC00000.
- An out-of-range exponent saturates to a signed infinity or collapses to a signed zero, and raises its flag.
- Denormal operands are flushed to zero.

By default the result is registered one cycle after a valid input. A parameter selects a purely combinational path instead.

Top module: `fpm_top`

## Requirements
- R1: For two normal operands whose result is in range, the output word is {sign, exponent, fraction} built as described in R2 to R4. For example, 0xC1980000 (-19.0) times 0x41180000 (9.5) gives 0xC3348000 (-180.5).
- R2: The result sign bit (bit 31) is the XOR of the two operand sign bits, for every result except the quiet NaN.
- R3: When bit 47 of the significand product is 1, the biased exponent is ea + eb - 127 + 1 and the fraction is product bits 46:24.
- R4: When bit 47 is 0, the exponent is ea + eb - 127 and the fraction is product bits 45:23. Lower product bits are discarded (truncation, no rounding).
- R5: classA and classB report each operand's class with the codes 0 zero (exponent 0, fraction 0), 1 denormal (exponent 0, fraction nonzero), 2 normal (exponent 1 to 254), 3 infinity (exponent 255, fraction 0) and 4 NaN (exponent 255, fraction nonzero).
- R6: If the normalized exponent of two normal operands is 255 or more, the output is a signed infinity and flagOverflow is 1.
- R7: If the normalized exponent of two normal operands is 0 or less, the output is a signed zero and flagUnderflow is 1.
- R8: If either operand is NaN, or an infinity meets a zero or denormal, the output is 0x7FC00000 and flagInvalid is 1. At most one flag is ever set.
- R9: Apart from R8, an infinity operand gives a signed infinity, and a zero or denormal operand gives a signed zero. Neither case raises a flag.
- R10: classRes reports the class of the output word with the R5 codes, and it is 4 exactly when flagInvalid is 1.
- R11: With the output register on, the result, flags and classes appear on the cycle after inValid is sampled high, and outValid follows inValid by one cycle. While inValid is low, the outputs hold.
- R12: After reset the output word, the flags and outValid are 0, and all class codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operands valid this cycle |
| inA | input | 32 | First operand |
| inB | input | 32 | Second operand |
| outValid | output | 1 | Result valid |
| outProd | output | 32 | Product word |
| flagOverflow | output | 1 | Exponent overflow, result saturated to infinity |
| flagUnderflow | output | 1 | Exponent underflow, result flushed to zero |
| flagInvalid | output | 1 | Invalid operation, result is quiet NaN |
| classA | output | 3 | Class code of operand A |
| classB | output | 3 | Class code of operand B |
| classRes | output | 3 | Class code of the result |

## Verification
The assertions assume that inValid is held low while reset is asserted. The latency and hold properties compare against the input seen in the cycle before, so this keeps the first cycle after reset consistent. They also assume the default registered configuration. The bench drives inValid low through reset and gives each operand pair for exactly one cycle. Between pairs, inValid returns to low, and the hold check changes the operands only while inValid is low.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int EI_W    = EXP_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fpClass_e;

  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              ovf;
    logic              unf;
    logic              inv;
    fpClass_e          clsA;
    fpClass_e          clsB;
    fpClass_e          clsRes;
  } mulResult_t;
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
(
  input  logic [EXP_W-1:0]  expIn,
  input  logic [FRAC_W-1:0] fracIn,
  output fpClass_e          cls
);
  logic expAllZero;
  logic expAllOne;
  logic fracZero;

  assign expAllZero = (expIn == '0);
  assign expAllOne  = (expIn == {EXP_W{1'b1}});
  assign fracZero   = (fracIn == '0);

  always_comb begin
    if (expAllZero)     cls = fracZero ? CLS_ZERO : CLS_SUB;
    else if (expAllOne) cls = fracZero ? CLS_INF  : CLS_NAN;
    else                cls = CLS_NORM;
  end
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul
  import fpm_pkg::*;
(
  input  logic [FRAC_W-1:0] fracA,
  input  logic [FRAC_W-1:0] fracB,
  output logic [PROD_W-1:0] prod
);
  logic [SIG_W-1:0] sigA;
  logic [SIG_W-1:0] sigB;

  assign sigA = {1'b1, fracA};
  assign sigB = {1'b1, fracB};
  assign prod = PROD_W'(sigA) * PROD_W'(sigB);
endmodule

// File: rtl/fpm_control.sv
module fpm_control
  import fpm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  assign strobe.capture = inValid;

  if (REG_OUT) begin : g_regValid
    logic validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= inValid;
    end
    assign outValid = validQ;
  end else begin : g_combValid
    assign outValid = inValid;
  end
endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] inA,
  input  logic [WORD_W-1:0] inB,
  output mulResult_t        res
);
  localparam logic signed [EI_W-1:0] E_MAX_S = EI_W'(EXP_MAX);
  localparam logic signed [EI_W-1:0] E_BIAS_S = EI_W'(BIAS);

  logic [EXP_W-1:0]  opExp  [2];
  logic [FRAC_W-1:0] opFrac [2];
  fpClass_e          opCls  [2];

  assign opExp[0]  = inA[WORD_W-2 -: EXP_W];
  assign opExp[1]  = inB[WORD_W-2 -: EXP_W];
  assign opFrac[0] = inA[FRAC_W-1:0];
  assign opFrac[1] = inB[FRAC_W-1:0];

  for (genvar gi = 0; gi < 2; gi++) begin : g_opClass
    fpm_classify u_cls (
      .expIn  (opExp[gi]),
      .fracIn (opFrac[gi]),
      .cls    (opCls[gi])
    );
  end

  logic [PROD_W-1:0] prod;
  fpm_sigmul u_mul (
    .fracA (opFrac[0]),
    .fracB (opFrac[1]),
    .prod  (prod)
  );

  // Normalization: one-bit check of the product top bit
  logic              topBit;
  logic [PROD_W-1:0] normProd;
  logic [FRAC_W-1:0] normFrac;

  assign topBit   = prod[PROD_W-1];
  assign normProd = topBit ? prod : (prod << 1);
  assign normFrac = FRAC_W'(normProd >> SIG_W);

  // Exponent in a widened signed intermediate
  logic signed [EI_W-1:0] expSum;
  assign expSum = $signed(EI_W'(opExp[0])) + $signed(EI_W'(opExp[1]))
                - E_BIAS_S + $signed(EI_W'(topBit));

  logic resSign;
  assign resSign = inA[WORD_W-1] ^ inB[WORD_W-1];

  logic anyNan;
  logic anyInf;
  logic anyZero;
  assign anyNan  = (opCls[0] == CLS_NAN) || (opCls[1] == CLS_NAN);
  assign anyInf  = (opCls[0] == CLS_INF) || (opCls[1] == CLS_INF);
  assign anyZero = (opCls[0] == CLS_ZERO) || (opCls[0] == CLS_SUB)
                || (opCls[1] == CLS_ZERO) || (opCls[1] == CLS_SUB);

  logic [WORD_W-1:0] resWord;
  logic              ovfN;
  logic              unfN;
  logic              invN;

  always_comb begin
    ovfN = 1'b0;
    unfN = 1'b0;
    invN = 1'b0;
    if (anyNan || (anyInf && anyZero)) begin
      resWord = QNAN_WORD;
      invN    = 1'b1;
    end else if (anyInf) begin
      resWord = {resSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (anyZero) begin
      resWord = {resSign, {(WORD_W-1){1'b0}}};
    end else if (expSum >= E_MAX_S) begin
      resWord = {resSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovfN    = 1'b1;
    end else if (expSum <= 0) begin
      resWord = {resSign, {(WORD_W-1){1'b0}}};
      unfN    = 1'b1;
    end else begin
      resWord = {resSign, expSum[EXP_W-1:0], normFrac};
    end
  end

  fpClass_e resCls;
  fpm_classify u_resCls (
    .expIn  (resWord[WORD_W-2 -: EXP_W]),
    .fracIn (resWord[FRAC_W-1:0]),
    .cls    (resCls)
  );

  mulResult_t nxt;
  always_comb begin
    nxt.word   = resWord;
    nxt.ovf    = ovfN;
    nxt.unf    = unfN;
    nxt.inv    = invN;
    nxt.clsA   = opCls[0];
    nxt.clsB   = opCls[1];
    nxt.clsRes = resCls;
  end

  if (REG_OUT) begin : g_outReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               res <= '0;
      else if (strobe.capture) res <= nxt;
    end
  end else begin : g_outComb
    assign res = nxt;
  end
endmodule

// File: rtl/fpm_top.sv
module fpm_top
  import fpm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inA,
  input  logic [WORD_W-1:0] inB,
  output logic              outValid,
  output logic [WORD_W-1:0] outProd,
  output logic              flagOverflow,
  output logic              flagUnderflow,
  output logic              flagInvalid,
  output logic [2:0]        classA,
  output logic [2:0]        classB,
  output logic [2:0]        classRes
);
  ctrlStrobe_t strobe;
  mulResult_t  res;

  fpm_control #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fpm_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inA    (inA),
    .inB    (inB),
    .res    (res)
  );

  assign outProd       = res.word;
  assign flagOverflow  = res.ovf;
  assign flagUnderflow = res.unf;
  assign flagInvalid   = res.inv;
  assign classA        = res.clsA;
  assign classB        = res.clsB;
  assign classRes      = res.clsRes;
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker
  import fpm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [WORD_W-1:0] inA,
  input logic [WORD_W-1:0] inB,
  input logic              outValid,
  input logic [WORD_W-1:0] outProd,
  input logic              flagOverflow,
  input logic              flagUnderflow,
  input logic              flagInvalid,
  input logic [2:0]        classRes
);
  AST_OVF_GIVES_INF: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> (outProd[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R6

  AST_UNF_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> (outProd[WORD_W-2:0] == '0)); // R7

  AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> (outProd == QNAN_WORD)); // R8

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagOverflow, flagUnderflow, flagInvalid})); // R8

  AST_NAN_CLASS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (classRes == 3'd4) == flagInvalid); // R10

  if (REG_OUT) begin : g_seqChecks
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
      outValid == $past(inValid)); // R11

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !$past(inValid) |-> $stable(outProd)); // R11

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && !flagInvalid) |->
        (outProd[WORD_W-1] == $past(inA[WORD_W-1] ^ inB[WORD_W-1]))); // R2
  end
endmodule

bind fpm_top fpm_checker #(.REG_OUT(REG_OUT)) u_fpmChecker (
  .clk           (clk),
  .rstN          (rstN),
  .inValid       (inValid),
  .inA           (inA),
  .inB           (inB),
  .outValid      (outValid),
  .outProd       (outProd),
  .flagOverflow  (flagOverflow),
  .flagUnderflow (flagUnderflow),
  .flagInvalid   (flagInvalid),
  .classRes      (classRes)
);

// File: tb/fpm_top_tb_top.sv
module fpm_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inA = '0;
  logic [31:0] inB = '0;
  logic        outValid;
  logic [31:0] outProd;
  logic        flagOverflow;
  logic        flagUnderflow;
  logic        flagInvalid;
  logic [2:0]  classA;
  logic [2:0]  classB;
  logic [2:0]  classRes;

  int checks = 0;
  int errors = 0;
  bit summaryDone = 1'b0;

  always #10 clk = ~clk;

  fpm_top dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .inA           (inA),
    .inB           (inB),
    .outValid      (outValid),
    .outProd       (outProd),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow),
    .flagInvalid   (flagInvalid),
    .classA        (classA),
    .classB        (classB),
    .classRes      (classRes)
  );

  task automatic expectEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One valid cycle; leaves the clock at the negedge after the capture edge
  task automatic applyOp(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    inA = a;
    inB = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkMul(string tag, logic [31:0] a, logic [31:0] b,
                          logic [31:0] expWord, logic [2:0] expFlags);
    applyOp(a, b);
    expectEq({tag, " word"}, outProd, expWord);
    expectEq({tag, " flags ovf/unf/inv"},
             {29'b0, flagOverflow, flagUnderflow, flagInvalid}, {29'b0, expFlags});
    expectEq({tag, " outValid"}, {31'b0, outValid}, 32'd1);
  endtask

  task automatic testReset();
    expectEq("R12 word", outProd, 32'h0);
    expectEq("R12 valid/flags", {28'b0, outValid, flagOverflow, flagUnderflow, flagInvalid}, 32'h0);
    expectEq("R12 classes", {23'b0, classA, classB, classRes}, 32'h0);
  endtask

  task automatic testVector();
    checkMul("R1 -19.0*9.5", 32'hC1980000, 32'h41180000, 32'hC3348000, 3'b000);
    expectEq("R5 normal classes", {23'b0, classA, classB, classRes}, {23'b0, 3'd2, 3'd2, 3'd2});
  endtask

  task automatic testNormalize();
    checkMul("R3 1.5*1.5", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 3'b000);
    checkMul("R4 1.0*1.0", 32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000);
    checkMul("R4 truncation", 32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000);
  endtask

  task automatic testSign();
    checkMul("R2 neg*neg", 32'hBF800000, 32'hBF800000, 32'h3F800000, 3'b000);
    checkMul("R2 pos*neg", 32'h3F800000, 32'hBFC00000, 32'hBFC00000, 3'b000);
  endtask

  task automatic testOverflow();
    checkMul("R6 overflow", 32'h7F000000, 32'h40000000, 32'h7F800000, 3'b100);
    expectEq("R10 class inf", {29'b0, classRes}, 32'd3);
    checkMul("R6 neg overflow", 32'hFF000000, 32'h40000000, 32'hFF800000, 3'b100);
    checkMul("R6 top boundary", 32'h7F000000, 32'h3F800000, 32'h7F000000, 3'b000);
  endtask

  task automatic testUnderflow();
    checkMul("R7 underflow", 32'h00800000, 32'h3F000000, 32'h00000000, 3'b010);
    checkMul("R7 neg underflow", 32'h80800000, 32'h3F000000, 32'h80000000, 3'b010);
    checkMul("R7 low boundary", 32'h00800000, 32'h3F800000, 32'h00800000, 3'b000);
  endtask

  task automatic testInvalid();
    checkMul("R8 inf*denormal", 32'h00000001, 32'h7F800000, 32'h7FC00000, 3'b001);
    expectEq("R5 denormal/inf classes", {26'b0, classA, classB}, {26'b0, 3'd1, 3'd3});
    expectEq("R10 class nan", {29'b0, classRes}, 32'd4);
    checkMul("R8 nan operand", 32'hFF800001, 32'h3F800000, 32'h7FC00000, 3'b001);
    expectEq("R5 nan class", {29'b0, classA}, 32'd4);
    checkMul("R8 zero*inf", 32'h80000000, 32'hFF800000, 32'h7FC00000, 3'b001);
  endtask

  task automatic testSpecials();
    checkMul("R9 zero*normal", 32'h3F800000, 32'h00000000, 32'h00000000, 3'b000);
    expectEq("R5 zero class", {29'b0, classB}, 32'd0);
    expectEq("R10 class zero", {29'b0, classRes}, 32'd0);
    checkMul("R9 denormal*neg", 32'h80000001, 32'h40000000, 32'h80000000, 3'b000);
    checkMul("R9 inf*normal", 32'hFF800000, 32'h40000000, 32'hFF800000, 3'b000);
    checkMul("R9 inf*inf", 32'h7F800000, 32'hFF800000, 32'hFF800000, 3'b000);
  endtask

  task automatic testHold();
    applyOp(32'hC1980000, 32'h41180000);
    expectEq("R11 product after capture", outProd, 32'hC3348000);
    inA = 32'h7F800001;
    inB = 32'h00000000;
    @(negedge clk);
    expectEq("R11 hold word", outProd, 32'hC3348000);
    expectEq("R11 valid low", {31'b0, outValid}, 32'd0);
    inA = 32'h7F000000;
    inB = 32'h40000000;
    @(negedge clk);
    expectEq("R11 hold flags", {29'b0, flagOverflow, flagUnderflow, flagInvalid}, 32'd0);
    expectEq("R11 hold word later", outProd, 32'hC3348000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testVector();
    testNormalize();
    testSign();
    testOverflow();
    testUnderflow();
    testInvalid();
    testSpecials();
    testHold();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end
endmodule